// File: doc/BRIEF.md
# Programmable Audio Frame-Sync Generator

This block produces the frame-sync (word-select) level for a TDM or I2S serial audio cluster. The reference is a bit clock. Each bit clock reaches the block as a single-cycle tick on one of several source lines, all in the system clock domain. A select field picks which line drives the generator. The frame has a high phase and a low phase, and each phase length is programmed on its own, in bit clocks, using a minus-one encoding. The frame length therefore equals the bit-clock-to-sample-rate ratio.

To get a near-even duty cycle for a frame of R bit clocks, software programs high = R/2 - 1 and low = (R+1)/2 - 1, using integer division. With an odd R, the low phase gets the extra bit clock. Beside the level, the block gives the serializers a one-cycle frame-start strobe. Period values are shadowed: a write made while a frame is running only takes effect when the next frame begins.

The generator is a three-state machine:
- IDLE: output low, counter cleared.
- HIGH: counting high-phase bit clocks.
- LOW: counting low-phase bit clocks.

Its transitions are:
- START: IDLE to HIGH on the first selected tick while enabled.
- HALF: HIGH to LOW on the tick that completes the high phase.
- WRAP: LOW to HIGH on the tick that completes the low phase.
- HALT: any state to IDLE whenever the block is disabled or no source is selected.

Both START and WRAP reload the period shadow and raise the frame-start strobe.

Top module: `fsg_frame_sync`

## Requirements
- R1: During and directly after reset, `fsync_o` and `frame_start_o` are both 0.
- R2: While `cfg_enable_i` is 0, both outputs stay 0 and ticks on every source line are ignored.
- R3: The select value 0, and any select value above NUM_SRC, mean "no source". With no source, the outputs stay 0 even when enabled, and the counter is held cleared.
- R4: A select value n+1 chooses tick line n. Ticks on the other lines change neither output.
- R5: The first selected tick after the generator leaves IDLE drives `fsync_o` high and pulses `frame_start_o`. Both show in the system clock cycle after the edge that samples that tick.
- R6: The high phase lasts high+1 selected ticks and the low phase lasts low+1 selected ticks, so a frame spans high+low+2 ticks. Between ticks, `fsync_o` holds its level.
- R7: `frame_start_o` is high for exactly one system clock cycle. This happens only on the cycle where a frame begins (START or WRAP), and `fsync_o` is high in that cycle.
- R8: Period values written while a frame is running do not change that frame. They are captured only at the next START or WRAP.
- R9: Clearing the enable mid-frame returns the generator to IDLE on the next clock edge, with `fsync_o` low. Enabling again restarts with a fresh high phase and a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_enable_i | input | 1 | Generation enable |
| cfg_clk_sel_i | input | SEL_W (4) | Bit-clock source select: 0 = none, n+1 = line n |
| cfg_hi_period_i | input | PERIOD_W (16) | High-phase length in bit clocks, minus one |
| cfg_lo_period_i | input | PERIOD_W (16) | Low-phase length in bit clocks, minus one |
| bclk_tick_i | input | NUM_SRC (4) | One-cycle bit-clock ticks, one per source line |
| fsync_o | output | 1 | Frame-sync level |
| frame_start_o | output | 1 | One-cycle strobe at the start of each frame |

## Verification
Two events can land in the same cycle: a frame boundary reloading the period shadow, and software writing new period values. Which frame the new values govern depends on their relative order. The bench changes both periods partway through a high phase, and it also sweeps every small high/low pair back to back. Its arithmetic model latches periods only at the tick where the frame position wraps to zero. Any mismatch in when the new duty cycle first appears is therefore reported against R8 or R6.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    // Phase state of the frame-sync generator
    typedef enum logic [1:0] {
        FSG_IDLE = 2'd0,
        FSG_HIGH = 2'd1,
        FSG_LOW  = 2'd2
    } fsg_state_e;

endpackage

// File: rtl/fsg_src_mux.sv
// Picks one bit-clock tick line according to a select code where
// 0 means "no source" and n+1 means line n.
module fsg_src_mux #(
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 4
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_SRC-1:0] ticks_i,
    output logic               src_ok_o,
    output logic               tick_o
);

    localparam int MAX_CODES = 1 << SEL_W;

    logic [NUM_SRC-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_dec
            if (g + 1 < MAX_CODES) begin : g_reach
                assign hit[g] = (sel_i == SEL_W'(g + 1));
            end else begin : g_unreach
                assign hit[g] = 1'b0;
            end
        end
    endgenerate

    assign src_ok_o = |hit;
    assign tick_o   = |(hit & ticks_i);

endmodule

// File: rtl/fsg_period_shadow.sv
// Holds the period pair that governs the running frame; reloads
// only when the phase machine signals a frame start.
module fsg_period_shadow #(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  logic [PERIOD_W-1:0] hi_i,
    input  logic [PERIOD_W-1:0] lo_i,
    output logic [PERIOD_W-1:0] hi_o,
    output logic [PERIOD_W-1:0] lo_o
);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_o <= '0;
            lo_o <= '0;
        end else if (load_i) begin
            hi_o <= hi_i;
            lo_o <= lo_i;
        end
    end

endmodule

// File: rtl/fsg_phase_fsm.sv
// IDLE / HIGH / LOW machine with a shared phase counter.
module fsg_phase_fsm
    import fsg_pkg::*;
#(
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                run_i,
    input  logic                tick_i,
    input  logic [PERIOD_W-1:0] hi_i,
    input  logic [PERIOD_W-1:0] lo_i,
    output logic                load_o,
    output logic                fsync_o,
    output logic                frame_start_o
);

    fsg_state_e          state_q, state_d;
    logic [PERIOD_W-1:0] cnt_q, cnt_d;

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        load_o  = 1'b0;
        if (!run_i) begin
            // HALT
            state_d = FSG_IDLE;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                FSG_IDLE: begin
                    if (tick_i) begin
                        // START
                        state_d = FSG_HIGH;
                        cnt_d   = '0;
                        load_o  = 1'b1;
                    end
                end
                FSG_HIGH: begin
                    if (tick_i) begin
                        if (cnt_q == hi_i) begin
                            // HALF
                            state_d = FSG_LOW;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                FSG_LOW: begin
                    if (tick_i) begin
                        if (cnt_q == lo_i) begin
                            // WRAP
                            state_d = FSG_HIGH;
                            cnt_d   = '0;
                            load_o  = 1'b1;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                default: begin
                    state_d = FSG_IDLE;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FSG_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Output register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            fsync_o       <= 1'b0;
            frame_start_o <= 1'b0;
        end else begin
            fsync_o       <= (state_d == FSG_HIGH);
            frame_start_o <= load_o;
        end
    end

endmodule

// File: rtl/fsg_frame_sync.sv
module fsg_frame_sync #(
    parameter int NUM_SRC  = 4,
    parameter int SEL_W    = 4,
    parameter int PERIOD_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                cfg_enable_i,
    input  logic [SEL_W-1:0]    cfg_clk_sel_i,
    input  logic [PERIOD_W-1:0] cfg_hi_period_i,
    input  logic [PERIOD_W-1:0] cfg_lo_period_i,
    input  logic [NUM_SRC-1:0]  bclk_tick_i,
    output logic                fsync_o,
    output logic                frame_start_o
);

    logic                src_ok;
    logic                tick_sel;
    logic                load;
    logic [PERIOD_W-1:0] hi_sh;
    logic [PERIOD_W-1:0] lo_sh;

    fsg_src_mux #(
        .NUM_SRC (NUM_SRC),
        .SEL_W   (SEL_W)
    ) src_mux_i (
        .sel_i    (cfg_clk_sel_i),
        .ticks_i  (bclk_tick_i),
        .src_ok_o (src_ok),
        .tick_o   (tick_sel)
    );

    fsg_period_shadow #(
        .PERIOD_W (PERIOD_W)
    ) shadow_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .hi_i   (cfg_hi_period_i),
        .lo_i   (cfg_lo_period_i),
        .hi_o   (hi_sh),
        .lo_o   (lo_sh)
    );

    fsg_phase_fsm #(
        .PERIOD_W (PERIOD_W)
    ) fsm_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .run_i         (cfg_enable_i & src_ok),
        .tick_i        (tick_sel),
        .hi_i          (hi_sh),
        .lo_i          (lo_sh),
        .load_o        (load),
        .fsync_o       (fsync_o),
        .frame_start_o (frame_start_o)
    );

endmodule

// File: rtl/fsg_frame_sync_chk.sv
module fsg_frame_sync_chk #(
    parameter int NUM_SRC  = 4,
    parameter int SEL_W    = 4,
    parameter int PERIOD_W = 16
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                cfg_enable_i,
    input logic [SEL_W-1:0]    cfg_clk_sel_i,
    input logic [PERIOD_W-1:0] cfg_hi_period_i,
    input logic [PERIOD_W-1:0] cfg_lo_period_i,
    input logic [NUM_SRC-1:0]  bclk_tick_i,
    input logic                fsync_o,
    input logic                frame_start_o
);

    logic chk_src_ok;
    logic chk_tick;

    always_comb begin
        chk_src_ok = 1'b0;
        chk_tick   = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (int'(cfg_clk_sel_i) == i + 1) begin
                chk_src_ok = 1'b1;
                chk_tick   = bclk_tick_i[i];
            end
        end
    end

    AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cfg_enable_i |=> (!fsync_o && !frame_start_o)); // R2

    AST_NOSRC_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !chk_src_ok |=> (!fsync_o && !frame_start_o)); // R3

    AST_HOLD_WITHOUT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_enable_i && chk_src_ok && !chk_tick) |=> ($stable(fsync_o) && !frame_start_o)); // R4

    AST_RISE_STROBES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(fsync_o) |-> frame_start_o); // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |=> !frame_start_o); // R7

    AST_STROBE_IN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> fsync_o); // R7

endmodule

bind fsg_frame_sync fsg_frame_sync_chk #(
    .NUM_SRC  (NUM_SRC),
    .SEL_W    (SEL_W),
    .PERIOD_W (PERIOD_W)
) chk_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .cfg_enable_i    (cfg_enable_i),
    .cfg_clk_sel_i   (cfg_clk_sel_i),
    .cfg_hi_period_i (cfg_hi_period_i),
    .cfg_lo_period_i (cfg_lo_period_i),
    .bclk_tick_i     (bclk_tick_i),
    .fsync_o         (fsync_o),
    .frame_start_o   (frame_start_o)
);

// File: tb/fsg_frame_sync_tb_top.sv
module fsg_frame_sync_tb_top;

    localparam int NS = 4;
    localparam int SW = 4;
    localparam int PW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          en;
    logic [SW-1:0] sel;
    logic [PW-1:0] hi;
    logic [PW-1:0] lo;
    logic [NS-1:0] tick;
    logic          fsync;
    logic          fstart;

    int n_vec = 0;
    int n_bad = 0;

    // Bench model state
    bit m_act = 1'b0;
    int m_pos = 0;
    int m_hi  = 0;
    int m_lo  = 0;

    always #10 clk = ~clk;

    fsg_frame_sync #(
        .NUM_SRC  (NS),
        .SEL_W    (SW),
        .PERIOD_W (PW)
    ) dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .cfg_enable_i    (en),
        .cfg_clk_sel_i   (sel),
        .cfg_hi_period_i (hi),
        .cfg_lo_period_i (lo),
        .bclk_tick_i     (tick),
        .fsync_o         (fsync),
        .frame_start_o   (fstart)
    );

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {fsync,strobe} actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Apply one cycle of ticks, advance the model, sample after the edge.
    task automatic step(input logic [NS-1:0] tk, input string req);
        int   idx;
        bit   src_ok;
        bit   hit;
        logic exp_fs;
        logic exp_st;
        tick   = tk;
        idx    = int'(sel) - 1;
        src_ok = (idx >= 0) && (idx < NS);
        hit    = 1'b0;
        if (en && src_ok) hit = tk[idx];
        exp_st = 1'b0;
        if (!en || !src_ok) begin
            m_act = 1'b0;
        end else if (hit) begin
            if (!m_act) begin
                m_act  = 1'b1;
                m_pos  = 0;
                m_hi   = int'(hi);
                m_lo   = int'(lo);
                exp_st = 1'b1;
            end else begin
                m_pos++;
                if (m_pos == m_hi + m_lo + 2) begin
                    m_pos  = 0;
                    m_hi   = int'(hi);
                    m_lo   = int'(lo);
                    exp_st = 1'b1;
                end
            end
        end
        exp_fs = m_act && (m_pos <= m_hi);
        @(negedge clk);
        check(req, {fsync, fstart}, {exp_fs, exp_st});
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        en    = 1'b0;
        sel   = '0;
        hi    = '0;
        lo    = '0;
        tick  = '0;
        repeat (3) @(negedge clk);
        check("R1", {fsync, fstart}, 2'b00);
        rst_n = 1'b1;
        step('0, "R1");

        // R2: disabled, all ticks ignored
        sel = 4'd1;
        repeat (5) step('1, "R2");

        // R3: enabled but no source (code 0 and code above NUM_SRC)
        en  = 1'b1;
        sel = 4'd0;
        repeat (5) step('1, "R3");
        sel = 4'd5;
        repeat (3) step('1, "R3");
        sel = 4'd15;
        repeat (3) step('1, "R3");

        // R4/R5/R6/R7: sweep sources and small period pairs
        for (int s = 0; s < NS; s++) begin
            for (int h = 0; h < 5; h++) begin
                for (int l = 0; l < 5; l++) begin
                    logic [NS-1:0] own;
                    own = NS'(1) << s;
                    en  = 1'b0;
                    step('0, "R2");
                    sel = SW'(s + 1);
                    hi  = PW'(h);
                    lo  = PW'(l);
                    en  = 1'b1;
                    for (int k = 0; k < 3 * (h + l + 2); k++) begin
                        if (k == 0) step(own, "R5");
                        else        step(own, "R6 R7");
                        if (((k + s + h) % 3) == 0) step(~own, "R4");
                    end
                end
            end
        end

        // R8: periods changed in the middle of a high phase
        en  = 1'b0;
        step('0, "R2");
        sel = 4'd2;
        hi  = 16'd3;
        lo  = 16'd2;
        en  = 1'b1;
        repeat (3) step(4'b0010, "R8");
        hi = 16'd0;
        lo = 16'd0;
        repeat (12) step(4'b0010, "R8");
        // change on the very tick that closes the frame
        hi = 16'd2;
        lo = 16'd1;
        repeat (10) step(4'b0010, "R8");

        // R9: disable mid-frame, then restart
        hi = 16'd2;
        lo = 16'd2;
        repeat (4) step(4'b0010, "R9");
        en = 1'b0;
        step('0, "R9");
        en = 1'b1;
        step('0, "R9");
        step(4'b0010, "R9");
        repeat (6) step(4'b0010, "R9");

        // R3: source removed mid-frame
        sel = 4'd0;
        step(4'b0010, "R3");
        sel = 4'd2;
        repeat (4) step(4'b0010, "R5");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule